// File: doc/BRIEF.md
# Self-Timed Program Cycle Sequencer

This block carries out the timed internal programming operations of a serial non-volatile memory holding 256 words of 16 bits. An upstream decoder, which has already checked the instruction and any protection rules, hands over an approved request: an operation code, a word address and a data word. The sequencer holds that request until chip select falls. On that falling edge it starts a self-timed cycle. The cycle then runs to its end without any serial clock and whatever chip select does.

Four array operations are supported: erase of one word, write of one word with an automatic erase first, erase of the whole array, and write of one value to the whole array. Whole-array write always runs a full erase pass before its data pass. A fifth operation loads the protect register. Durations are parameters counted in system clocks.

While a cycle runs, the host can poll for status. It lowers chip select for a minimum time and then raises it again. The serial output then shows 0 while busy and 1 once ready, and goes back to high impedance when chip select falls.

Top module: `prog_cycle_seq`

## Requirements
- R1: After reset, busy, done, arr_we, prot_we and stat_oe are all 0.
- R2: An accepted request (req_op 0 erase, 1 write, 2 erase-all, 3 write-all, 4 protect load; codes 5 to 7 are dropped) starts nothing until cs falls. busy rises in the clock after the first clock edge that samples cs low.
- R3: Erase writes 16'hFFFF once to the requested address and keeps busy high for T_WORD clocks.
- R4: Write makes exactly two array writes to the requested address: 16'hFFFF in busy cycle 0, then the data in busy cycle 1. busy lasts T_WORD clocks.
- R5: Erase-all writes 16'hFFFF to every address in ascending order, one per clock. busy lasts T_ERAL clocks.
- R6: Write-all first writes 16'hFFFF to all 256 words. It then writes the data word to all 256 words, starting in busy cycle T_WRAL/2. busy lasts T_WRAL clocks, and there are 512 writes in total.
- R7: Protect load raises prot_we once, carrying the requested address on prot_wdata. busy lasts T_WORD clocks.
- R8: Once started, a cycle keeps its full length and its writes even when cs toggles during it.
- R9: done is a single-clock pulse, high in the first clock after busy falls.
- R10: Requests presented while busy are dropped. No cycle follows them on a later cs fall.
- R11: If cs rises after at least MIN_LOW clocks low during a cycle, stat_oe goes to 1. stat_val then reads 0 while busy and 1 once the cycle has ended. stat_oe returns to 0 one clock after cs falls.
- R12: stat_oe stays 0 if every low spell of cs during the cycle is shorter than MIN_LOW clocks, or if cs stays low for the whole cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Approved request present |
| req_op | input | 3 | Operation code |
| req_addr | input | 8 | Word address, or protect register value |
| req_data | input | 16 | Data word for write and write-all |
| cs | input | 1 | Chip select level |
| busy | output | 1 | Self-timed cycle in progress |
| done | output | 1 | One-clock pulse at cycle end |
| arr_we | output | 1 | Array word write strobe |
| arr_addr | output | 8 | Array write address |
| arr_wdata | output | 16 | Array write data |
| prot_we | output | 1 | Protect register load strobe |
| prot_wdata | output | 8 | Protect register load value |
| stat_oe | output | 1 | Drive status on the serial output |
| stat_val | output | 1 | Status value: 0 busy, 1 ready |

## Verification
The bench mirrors every array write into its own model. After each operation it compares all 256 words against values it computes itself. This exposes a write that swaps the erase and data steps, a whole-array write that skips its erase pass or starts its data pass in the wrong cycle, and a sweep that misses an address.

Chip select is driven in three patterns:
- held low for the whole cycle;
- toggled in short spells below the minimum low time;
- lowered long enough and then raised to poll.

A design that shows status without a qualifying low spell, keeps showing it after the falling edge, or cuts the cycle short on a toggle would give a wrong status or a wrong busy count. A request injected mid-cycle, followed by an extra chip-select fall, catches a design that queues requests instead of dropping them.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    typedef enum logic [2:0] {
        OP_ERASE = 3'd0,
        OP_WRITE = 3'd1,
        OP_ERALL = 3'd2,
        OP_WRALL = 3'd3,
        OP_PROT  = 3'd4
    } op_e;

    localparam logic [2:0] OP_LAST = 3'd4;
endpackage

// File: rtl/pcs_step.sv
module pcs_step
    import pcs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 10,
    parameter int HALF   = 300
) (
    input  logic              active,
    input  op_e               op,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [DATA_W-1:0] wdata,
    output logic              prot_we,
    output logic [ADDR_W-1:0] prot_wdata
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [CNT_W-1:0] DEPTH_C  = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] HALF_C   = CNT_W'(HALF);
    localparam logic [CNT_W-1:0] HALF_E_C = CNT_W'(HALF + DEPTH);
    localparam logic [DATA_W-1:0] ONES    = '1;

    logic [CNT_W-1:0] off;

    always_comb begin
        off        = cnt - HALF_C;
        we         = 1'b0;
        waddr      = addr;
        wdata      = ONES;
        prot_we    = 1'b0;
        prot_wdata = addr;
        if (active) begin
            unique case (op)
                OP_ERASE: we = (cnt == '0);
                OP_WRITE: begin
                    we    = (cnt < CNT_W'(2));
                    wdata = (cnt == '0) ? ONES : data;
                end
                OP_ERALL: begin
                    we    = (cnt < DEPTH_C);
                    waddr = cnt[ADDR_W-1:0];
                end
                OP_WRALL: begin
                    if (cnt < DEPTH_C) begin
                        we    = 1'b1;
                        waddr = cnt[ADDR_W-1:0];
                    end else if (cnt >= HALF_C && cnt < HALF_E_C) begin
                        we    = 1'b1;
                        waddr = off[ADDR_W-1:0];
                        wdata = data;
                    end
                end
                OP_PROT: prot_we = (cnt == '0);
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pcs_status.sv
module pcs_status #(
    parameter int MIN_LOW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic launch,
    input  logic finish,
    input  logic busy,
    output logic stat_oe,
    output logic stat_val
);
    localparam int LW = $clog2(MIN_LOW + 1);
    localparam logic [LW-1:0] MIN_C = LW'(MIN_LOW);

    typedef struct packed {
        logic          cs_q;
        logic          mon;
        logic          disp;
        logic [LW-1:0] lowcnt;
    } st_t;

    st_t st_q, st_d;
    logic rise, fall;

    always_comb begin
        st_d      = st_q;
        st_d.cs_q = cs;
        rise      = cs & ~st_q.cs_q;
        fall      = ~cs & st_q.cs_q;
        if (cs)
            st_d.lowcnt = '0;
        else if (st_q.lowcnt != MIN_C)
            st_d.lowcnt = st_q.lowcnt + 1'b1;

        if (launch) begin
            st_d.mon  = 1'b1;
            st_d.disp = 1'b0;
        end else begin
            if (fall) begin
                st_d.disp = 1'b0;
                if (st_q.disp && !busy)
                    st_d.mon = 1'b0;
            end else if (rise && st_q.mon && st_q.lowcnt == MIN_C) begin
                st_d.disp = 1'b1;
            end
            if (finish && !st_q.disp)
                st_d.mon = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '{cs_q: 1'b1, mon: 1'b0, disp: 1'b0, lowcnt: '0};
        else
            st_q <= st_d;
    end

    assign stat_oe  = st_q.disp;
    assign stat_val = ~busy;

    // R11
    stat_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_oe && !cs |=> !stat_oe);

    // R12
    stat_qualify_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_oe) |-> $past(st_q.lowcnt) == MIN_C);
endmodule

// File: rtl/prog_cycle_seq.sv
module prog_cycle_seq
    import pcs_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 16,
    parameter int T_WORD  = 40,
    parameter int T_ERAL  = 300,
    parameter int T_WRAL  = 600,
    parameter int MIN_LOW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              cs,
    output logic              busy,
    output logic              done,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    output logic              prot_we,
    output logic [ADDR_W-1:0] prot_wdata,
    output logic              stat_oe,
    output logic              stat_val
);
    localparam int CNT_W = $clog2(T_WRAL + 1);
    localparam int HALF  = T_WRAL / 2;
    localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(T_WORD - 1);
    localparam logic [CNT_W-1:0] LAST_ERAL = CNT_W'(T_ERAL - 1);
    localparam logic [CNT_W-1:0] LAST_WRAL = CNT_W'(T_WRAL - 1);

    typedef struct packed {
        logic              armed;
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic              done;
        logic              cs_q;
    } ctl_t;

    ctl_t ctl_q, ctl_d;
    logic [CNT_W-1:0] last;
    logic launch, finish, accept;

    always_comb begin
        unique case (ctl_q.op)
            OP_ERALL: last = LAST_ERAL;
            OP_WRALL: last = LAST_WRAL;
            default:  last = LAST_WORD;
        endcase
        accept = !ctl_q.busy && req_valid && (req_op <= OP_LAST);
        launch = !ctl_q.busy && !accept && ctl_q.armed && ctl_q.cs_q && !cs;
        finish = ctl_q.busy && (ctl_q.cnt == last);

        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        ctl_d.cs_q = cs;
        if (accept) begin
            ctl_d.armed = 1'b1;
            ctl_d.op    = op_e'(req_op);
            ctl_d.addr  = req_addr;
            ctl_d.data  = req_data;
        end else if (launch) begin
            ctl_d.armed = 1'b0;
            ctl_d.busy  = 1'b1;
            ctl_d.cnt   = '0;
        end else if (finish) begin
            ctl_d.busy = 1'b0;
            ctl_d.done = 1'b1;
            ctl_d.cnt  = '0;
        end else if (ctl_q.busy) begin
            ctl_d.cnt = ctl_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctl_q <= '{armed: 1'b0, op: OP_ERASE, addr: '0, data: '0,
                       busy: 1'b0, cnt: '0, done: 1'b0, cs_q: 1'b1};
        else
            ctl_q <= ctl_d;
    end

    assign busy = ctl_q.busy;
    assign done = ctl_q.done;

    pcs_step #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .HALF(HALF)
    ) u_step (
        .active    (ctl_q.busy),
        .op        (ctl_q.op),
        .cnt       (ctl_q.cnt),
        .addr      (ctl_q.addr),
        .data      (ctl_q.data),
        .we        (arr_we),
        .waddr     (arr_addr),
        .wdata     (arr_wdata),
        .prot_we   (prot_we),
        .prot_wdata(prot_wdata)
    );

    pcs_status #(.MIN_LOW(MIN_LOW)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs      (cs),
        .launch  (launch),
        .finish  (finish),
        .busy    (ctl_q.busy),
        .stat_oe (stat_oe),
        .stat_val(stat_val)
    );

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    busy_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R2
    start_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(cs));

    // R8
    write_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we || prot_we) |-> busy);
endmodule

// File: tb/prog_cycle_seq_tb.sv
module prog_cycle_seq_tb;
    localparam int T_WORD  = 40;
    localparam int T_ERAL  = 300;
    localparam int T_WRAL  = 600;
    localparam int MIN_LOW = 4;
    localparam int DEPTH   = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = 3'd0;
    logic [7:0]  req_addr = 8'd0;
    logic [15:0] req_data = 16'd0;
    logic        cs = 1'b1;
    logic        busy, done, arr_we, prot_we, stat_oe, stat_val;
    logic [7:0]  arr_addr, prot_wdata;
    logic [15:0] arr_wdata;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    logic [15:0] mem [DEPTH];
    logic [15:0] expv [DEPTH];
    int prot_val;

    always #2 clk = ~clk;

    prog_cycle_seq #(.T_WORD(T_WORD), .T_ERAL(T_ERAL), .T_WRAL(T_WRAL),
                     .MIN_LOW(MIN_LOW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .cs(cs), .busy(busy),
        .done(done), .arr_we(arr_we), .arr_addr(arr_addr),
        .arr_wdata(arr_wdata), .prot_we(prot_we), .prot_wdata(prot_wdata),
        .stat_oe(stat_oe), .stat_val(stat_val)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp_v);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp_v);
        end
    endtask

    task automatic cmp_mem(input string req);
        int bad = 0;
        int first = -1;
        for (int i = 0; i < DEPTH; i++)
            if (mem[i] !== expv[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        if (first < 0) chk(1'b1, req, "array contents", 0, 0);
        else chk(1'b0, req, $sformatf("word %0d", first),
                 int'(mem[first]), int'(expv[first]));
    endtask

    // mode 0: cs low throughout; 1: short toggles; 2: status poll; 3: mid-cycle request
    task automatic run_op(input int op, input int a, input int d, input int mode,
                          input int dur, input int exp_wr, input int exp_first,
                          input int exp_prot, input string req);
        int busy_n = 0;
        int writes = 0;
        int first_data = -1;
        int prot_n = 0;
        int stat_bad = 0;
        bit ended = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'(op); req_addr = 8'(a); req_data = 16'(d); cs = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R2", "busy before cs fall", int'(busy), 0);
        cs = 1'b0;
        for (int k = 1; k < dur + 20; k++) begin
            @(negedge clk);
            if (k == 1) chk(busy == 1'b1, "R2", "busy after cs fall", int'(busy), 1);
            if (arr_we) begin
                mem[arr_addr] = arr_wdata;
                writes++;
                if (arr_wdata != 16'hFFFF && first_data < 0) first_data = k - 1;
            end
            if (prot_we) begin
                prot_n++;
                prot_val = int'(prot_wdata);
            end
            if (!busy) begin
                ended = 1'b1;
                chk(done == 1'b1, "R9", "done at end", int'(done), 1);
                if (mode == 2) begin
                    chk(stat_oe && stat_val, "R11", "ready shown",
                        int'({stat_oe, stat_val}), 3);
                    cs = 1'b0;
                end
                break;
            end
            busy_n++;
            if (mode != 2 && stat_oe) stat_bad++;
            if (mode == 1) begin
                if (k % 4 == 2) cs = 1'b1;
                if (k % 4 == 0) cs = 1'b0;
            end
            if (mode == 2) begin
                if (k == 6) cs = 1'b1;
                if (k == 7) chk(stat_oe && !stat_val, "R11", "busy shown",
                                int'({stat_oe, stat_val}), 2);
            end
            if (mode == 3) begin
                if (k == 3) begin
                    req_valid = 1'b1; req_op = 3'd0; req_addr = 8'd200;
                end
                if (k == 4) req_valid = 1'b0;
            end
        end
        chk(ended, req, "cycle ended", int'(ended), 1);
        chk(busy_n == dur, (mode == 1) ? "R8" : req, "busy length", busy_n, dur);
        chk(writes == exp_wr, req, "array write count", writes, exp_wr);
        chk(first_data == exp_first, req, "first data cycle", first_data, exp_first);
        chk(prot_n == exp_prot, "R7", "protect loads", prot_n, exp_prot);
        chk(stat_bad == 0, "R12", "status without poll", stat_bad, 0);
        @(negedge clk);
        chk(done == 1'b0, "R9", "done pulse width", int'(done), 0);
        if (mode == 2) chk(stat_oe == 1'b0, "R11", "release on cs fall", int'(stat_oe), 0);
        // after the cycle: raise and drop cs, nothing may start or show
        stat_bad = 0;
        writes = 0;
        cs = 1'b1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (stat_oe) stat_bad++;
            if (busy || arr_we) writes++;
            if (k == 3) cs = 1'b0;
        end
        chk(stat_bad == 0, "R12", "status after cycle", stat_bad, 0);
        chk(writes == 0, "R10", "activity after cycle", writes, 0);
        cs = 1'b1;
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = 16'h0;
            expv[i] = 16'h0;
        end
        repeat (5) @(negedge clk);
        chk(!busy && !done && !arr_we && !prot_we && !stat_oe, "R1", "reset outputs",
            int'({busy, done, arr_we, prot_we, stat_oe}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 erase-all
        for (int i = 0; i < DEPTH; i++) expv[i] = 16'hFFFF;
        run_op(2, 0, 0, 0, T_ERAL, DEPTH, -1, 0, "R5");
        cmp_mem("R5");

        // R4 write sweep, all cs patterns
        for (int i = 0; i < 12; i++) begin
            int a = (i == 0) ? 0 : (i == 11) ? 255 : (i * 53 + 7) % 256;
            int d = (a * 257) ^ 16'h5A3C;
            run_op(1, a, d, i % 3, T_WORD, 2, 1, 0, "R4");
            expv[a] = 16'(d);
            cmp_mem("R4");
        end

        // R3 erase
        run_op(0, 60, 0, 0, T_WORD, 1, -1, 0, "R3");
        expv[60] = 16'hFFFF;
        cmp_mem("R3");
        run_op(0, 255, 0, 1, T_WORD, 1, -1, 0, "R3");
        expv[255] = 16'hFFFF;
        cmp_mem("R3");

        // R6 write-all with status poll
        for (int i = 0; i < DEPTH; i++) expv[i] = 16'h1234;
        run_op(3, 0, 16'h1234, 2, T_WRAL, 2 * DEPTH, T_WRAL / 2, 0, "R6");
        cmp_mem("R6");

        // R7 protect load
        run_op(4, 8'hC3, 0, 1, T_WORD, 0, -1, 1, "R7");
        chk(prot_val == 8'hC3, "R7", "protect value", prot_val, 8'hC3);
        cmp_mem("R7");

        // R2 dropped op code
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'd5; cs = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        cs = 1'b0;
        begin
            int act = 0;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (busy || arr_we) act++;
            end
            chk(act == 0, "R2", "unused op code", act, 0);
        end
        cs = 1'b1;

        // R10 request during busy is dropped
        run_op(1, 9, 16'h0F0F, 3, T_WORD, 2, 1, 0, "R10");
        expv[9] = 16'h0F0F;
        cmp_mem("R10");

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule